// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block owns the write side of a circular receive area in local packet memory. Memory is handled in whole 256-byte pages: the upper address byte is a page number and the lower byte an offset within that page. The host programs a first page and a limit page (the ring covers the first page up to, but not including, the limit page). It also programs a boundary page, which marks data it has not read yet. The block keeps the current page, which is where the next frame will be placed.

Frames arrive from the MAC as a start strobe, a stream of byte strobes and an end strobe. The end strobe carries the CRC, alignment and group-address results. Data bytes are written from offset 4 of the current page onward, and the write pointer wraps from the last ring page to the first. After the end strobe the block either discards the frame or writes a 4-byte header into the first four bytes of the frame's first page and moves the current page past the frame. The header holds the status, the next page and the byte count. When a frame would run into the boundary, or when monitor mode is on, nothing is kept and a missed-frame pulse is raised.

Top module: `rxr_ring_mgr`

## Requirements
- R1: After reset the current page is 0, the last status is 0, and no memory write and no event pulse is active.
- R2: The first data byte of a frame is written at offset 4 of the current page, and each further byte is written at the next byte address.
- R3: When the write pointer leaves offset 255 of the page just below the limit page, it continues at offset 0 of the first ring page.
- R4: An accepted frame gets four header bytes, written after its end strobe, at offsets 0 to 3 of its first page: status, next page, (length+4) low byte, (length+4) high byte.
- R5: For an accepted frame, the next page is the ring page after the page that holds the frame's last byte. The current page becomes that value, and `frame_stored` pulses for one cycle.
- R6: Status byte bits: bit0 = no CRC or alignment error, bit1 = CRC or alignment error, bit2 = alignment error, bit4 = missed, bit5 = group address, bit6 = monitor mode; the other bits are 0.
- R7: A frame shorter than 64 bytes is discarded unless `cfg_keep_runt` is set. A discard pulses `frame_dropped`, loads its status into `last_status` and leaves the current page unchanged.
- R8: A frame with a CRC or alignment error is discarded in the same way unless `cfg_keep_bad` is set.
- R9: If a data byte would enter offset 0 of the boundary page, that byte and the rest of the frame are not written and `ring_overwrite` pulses. At the frame end, `frame_missed` pulses with status 0x10.
- R10: If an otherwise accepted frame would leave a next page equal to the boundary, it is not committed. `ring_overwrite` and `frame_missed` pulse together, and the status has bit4 added.
- R11: In monitor mode a frame causes no memory write. At its end, `frame_missed` pulses and the last status is 0x50.
- R12: Every memory write falls inside the ring (first page <= page < limit page).
- R13: A pulse on `cur_wr` while no frame is in progress loads `cur_wdata` into the current page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pg_first | input | 8 | First page of the ring |
| cfg_pg_limit | input | 8 | Page just past the ring |
| cfg_bnd | input | 8 | Boundary page owned by the host |
| cfg_keep_runt | input | 1 | Keep frames shorter than 64 bytes |
| cfg_keep_bad | input | 1 | Keep frames with CRC/alignment errors |
| cfg_monitor | input | 1 | Check frames but never store them |
| cur_wr | input | 1 | Host load strobe for current page |
| cur_wdata | input | 8 | Value for current page |
| rx_sof | input | 1 | Frame start strobe |
| rx_valid | input | 1 | Data byte strobe |
| rx_data | input | 8 | Data byte |
| rx_eof | input | 1 | Frame end strobe |
| rx_crc_err | input | 1 | CRC error, valid with rx_eof |
| rx_align_err | input | 1 | Alignment error, valid with rx_eof |
| rx_group | input | 1 | Group address match, valid with rx_eof |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_page | output | 8 | Current page |
| last_status | output | 8 | Status of the most recent frame |
| frame_stored | output | 1 | Frame committed pulse |
| frame_dropped | output | 1 | Frame discarded by filter pulse |
| frame_missed | output | 1 | Frame missed pulse |
| ring_overwrite | output | 1 | Boundary reached pulse |

## Verification
The bench aims at the wrap from the page below the limit page back to the first page. A design that got this wrong would scatter bytes outside the ring, or record a next page equal to the limit page. It drives frames that end exactly on a page edge, so a next-page value that is off by one shows up both in the header and in the current page. It hits the boundary both in the middle of a frame and exactly at a frame's end; a faulty block would overwrite unread data or commit a frame that makes the ring look empty. Runts at 63 and 64 bytes, errored frames with each keep bit set and clear, and monitor mode all check that discarded frames leave the current page unchanged and report the right status bits.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DROP = 2'd2,
        ST_HDR  = 2'd3
    } rxr_state_e;

    // status byte bit positions (read by host from the header)
    localparam int SB_INTACT = 0;
    localparam int SB_CRC    = 1;
    localparam int SB_ALIGN  = 2;
    localparam int SB_MISS   = 4;
    localparam int SB_GROUP  = 5;
    localparam int SB_MON    = 6;

    localparam int HDR_BYTES = 4;
endpackage

// File: rtl/rxr_page_step.sv
module rxr_page_step #(
    parameter int PG_W = 8
) (
    input  logic [PG_W-1:0] pg,
    input  logic [PG_W-1:0] pg_first,
    input  logic [PG_W-1:0] pg_limit,
    output logic [PG_W-1:0] pg_next
);
    logic [PG_W-1:0] inc;
    always_comb begin
        inc     = pg + PG_W'(1);
        pg_next = (inc == pg_limit) ? pg_first : inc;
    end
endmodule

// File: rtl/rxr_filter.sv
module rxr_filter #(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input  logic [LEN_W-1:0] len,
    input  logic             crc_err,
    input  logic             align_err,
    input  logic             group,
    input  logic             keep_runt,
    input  logic             keep_bad,
    output logic             keep,
    output logic [7:0]       status
);
    import rxr_pkg::*;
    logic runt, bad;
    always_comb begin
        runt   = (len < LEN_W'(MIN_LEN));
        bad    = crc_err | align_err;
        keep   = (!runt || keep_runt) && (!bad || keep_bad);
        status = '0;
        status[SB_INTACT] = !bad;
        status[SB_CRC]    = bad;
        status[SB_ALIGN]  = align_err;
        status[SB_GROUP]  = group;
    end
endmodule

// File: rtl/rxr_hdr_mux.sv
module rxr_hdr_mux #(
    parameter int PG_W  = 8,
    parameter int LEN_W = 16
) (
    input  logic [1:0]       idx,
    input  logic [7:0]       status,
    input  logic [PG_W-1:0]  next_pg,
    input  logic [LEN_W-1:0] count,
    output logic [7:0]       hbyte
);
    logic [15:0] c16;
    always_comb begin
        c16 = 16'(count);
        unique case (idx)
            2'd0: hbyte = status;
            2'd1: hbyte = 8'(next_pg);
            2'd2: hbyte = c16[7:0];
            default: hbyte = c16[15:8];
        endcase
    end
endmodule

// File: rtl/rxr_ring_mgr.sv
module rxr_ring_mgr #(
    parameter int PG_W    = 8,
    parameter int OFS_W   = 8,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PG_W-1:0]       cfg_pg_first,
    input  logic [PG_W-1:0]       cfg_pg_limit,
    input  logic [PG_W-1:0]       cfg_bnd,
    input  logic                  cfg_keep_runt,
    input  logic                  cfg_keep_bad,
    input  logic                  cfg_monitor,
    input  logic                  cur_wr,
    input  logic [PG_W-1:0]       cur_wdata,
    input  logic                  rx_sof,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic                  rx_eof,
    input  logic                  rx_crc_err,
    input  logic                  rx_align_err,
    input  logic                  rx_group,
    output logic                  mem_we,
    output logic [PG_W+OFS_W-1:0] mem_addr,
    output logic [7:0]            mem_wdata,
    output logic [PG_W-1:0]       cur_page,
    output logic [7:0]            last_status,
    output logic                  frame_stored,
    output logic                  frame_dropped,
    output logic                  frame_missed,
    output logic                  ring_overwrite
);
    import rxr_pkg::*;

    localparam int AW = PG_W + OFS_W;
    localparam logic [OFS_W-1:0] HDR_OFS  = OFS_W'(HDR_BYTES);
    localparam logic [OFS_W-1:0] OFS_LAST = '1;
    localparam logic [7:0] MISS_BIT = 8'(1 << SB_MISS);
    localparam logic [7:0] MON_BIT  = 8'(1 << SB_MON);

    typedef struct packed {
        rxr_state_e       st;
        logic [PG_W-1:0]  cur;
        logic [AW-1:0]    wptr;
        logic [LEN_W-1:0] len;
        logic [1:0]       hidx;
        logic [7:0]       stat;
        logic [PG_W-1:0]  nxt;
        logic [7:0]       last;
        logic             we;
        logic [AW-1:0]    addr;
        logic [7:0]       wdata;
        logic             ok;
        logic             drop;
        logic             miss;
        logic             ovw;
    } rxr_regs_t;

    rxr_regs_t q, d;

    logic [PG_W-1:0]  wpg, wpg_step, end_nxt;
    logic [OFS_W-1:0] wofs;
    logic             f_keep;
    logic [7:0]       f_stat;
    logic [7:0]       hbyte;
    logic [LEN_W-1:0] hcount;

    assign wpg    = q.wptr[AW-1:OFS_W];
    assign wofs   = q.wptr[OFS_W-1:0];
    assign hcount = q.len + LEN_W'(HDR_BYTES);

    rxr_page_step #(.PG_W(PG_W)) u_step (
        .pg(wpg), .pg_first(cfg_pg_first), .pg_limit(cfg_pg_limit), .pg_next(wpg_step)
    );

    rxr_filter #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_filt (
        .len(q.len), .crc_err(rx_crc_err), .align_err(rx_align_err), .group(rx_group),
        .keep_runt(cfg_keep_runt), .keep_bad(cfg_keep_bad), .keep(f_keep), .status(f_stat)
    );

    rxr_hdr_mux #(.PG_W(PG_W), .LEN_W(LEN_W)) u_hdr (
        .idx(q.hidx), .status(q.stat), .next_pg(q.nxt), .count(hcount), .hbyte(hbyte)
    );

    // next frame page: page of last byte rounded up (wptr already advanced)
    assign end_nxt = (wofs == '0) ? wpg : wpg_step;

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.ok   = 1'b0;
        d.drop = 1'b0;
        d.miss = 1'b0;
        d.ovw  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (rx_sof) begin
                    d.wptr = {q.cur, HDR_OFS};
                    d.len  = '0;
                    if (cfg_monitor) begin
                        d.st   = ST_DROP;
                        d.stat = MON_BIT | MISS_BIT;
                    end else begin
                        d.st = ST_RECV;
                    end
                end else if (cur_wr) begin
                    d.cur = cur_wdata;
                end
            end
            ST_RECV: begin
                if (rx_eof) begin
                    if (!f_keep) begin
                        d.drop = 1'b1;
                        d.last = f_stat;
                        d.st   = ST_IDLE;
                    end else if (end_nxt == cfg_bnd) begin
                        d.ovw  = 1'b1;
                        d.miss = 1'b1;
                        d.last = f_stat | MISS_BIT;
                        d.st   = ST_IDLE;
                    end else begin
                        d.stat = f_stat;
                        d.nxt  = end_nxt;
                        d.hidx = '0;
                        d.st   = ST_HDR;
                    end
                end else if (rx_valid) begin
                    if (wofs == '0 && wpg == cfg_bnd) begin
                        d.ovw  = 1'b1;
                        d.stat = MISS_BIT;
                        d.st   = ST_DROP;
                    end else begin
                        d.we    = 1'b1;
                        d.addr  = q.wptr;
                        d.wdata = rx_data;
                        d.wptr  = {(wofs == OFS_LAST) ? wpg_step : wpg, wofs + OFS_W'(1)};
                        d.len   = q.len + LEN_W'(1);
                    end
                end
            end
            ST_DROP: begin
                if (rx_eof) begin
                    d.miss = 1'b1;
                    d.last = q.stat;
                    d.st   = ST_IDLE;
                end
            end
            ST_HDR: begin
                d.we    = 1'b1;
                d.addr  = {q.cur, OFS_W'(q.hidx)};
                d.wdata = hbyte;
                d.hidx  = q.hidx + 2'd1;
                if (q.hidx == 2'(HDR_BYTES - 1)) begin
                    d.cur  = q.nxt;
                    d.ok   = 1'b1;
                    d.last = q.stat;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_we         = q.we;
    assign mem_addr       = q.addr;
    assign mem_wdata      = q.wdata;
    assign cur_page       = q.cur;
    assign last_status    = q.last;
    assign frame_stored   = q.ok;
    assign frame_dropped  = q.drop;
    assign frame_missed   = q.miss;
    assign ring_overwrite = q.ovw;

    // R12
    ring_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[AW-1:OFS_W] >= cfg_pg_first && mem_addr[AW-1:OFS_W] < cfg_pg_limit));

    // R7
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_stored, frame_dropped, frame_missed}));

    // R5
    cur_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_page) |-> (frame_stored || $past(cur_wr)));

    // R9
    ovw_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_overwrite |-> !mem_we);

    // R11
    drop_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DROP) |-> !mem_we);
endmodule

// File: tb/sim_rxr_ring_mgr.sv
module sim_rxr_ring_mgr;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    localparam logic [7:0] FIRST = 8'h40;
    localparam logic [7:0] LIMIT = 8'h46;

    logic [7:0]  cfg_bnd = 8'h00;
    logic        cfg_keep_runt = 0, cfg_keep_bad = 0, cfg_monitor = 0;
    logic        cur_wr = 0;
    logic [7:0]  cur_wdata = 0;
    logic        rx_sof = 0, rx_valid = 0, rx_eof = 0;
    logic [7:0]  rx_data = 0;
    logic        rx_crc_err = 0, rx_align_err = 0, rx_group = 0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, cur_page, last_status;
    logic        frame_stored, frame_dropped, frame_missed, ring_overwrite;

    rxr_ring_mgr u0 (
        .clk(clk), .rst_n(rst_n), .cfg_pg_first(FIRST), .cfg_pg_limit(LIMIT), .cfg_bnd(cfg_bnd),
        .cfg_keep_runt(cfg_keep_runt), .cfg_keep_bad(cfg_keep_bad), .cfg_monitor(cfg_monitor),
        .cur_wr(cur_wr), .cur_wdata(cur_wdata), .rx_sof(rx_sof), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_eof(rx_eof), .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err),
        .rx_group(rx_group), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_page(cur_page), .last_status(last_status), .frame_stored(frame_stored),
        .frame_dropped(frame_dropped), .frame_missed(frame_missed), .ring_overwrite(ring_overwrite)
    );

    int n_chk = 0, n_bad = 0;
    int n_wr, n_ok, n_drop, n_miss, n_ovw, n_oob;
    logic [7:0] bmem [0:4095];
    logic [7:0] dat [0:2047];
    logic [15:0] ea [0:2047];
    logic [7:0] exp_cur;
    bit done = 0;

    task automatic chk(bit cond, string req, int act, int exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pstep(logic [7:0] p);
        return (p + 8'd1 == LIMIT) ? FIRST : p + 8'd1;
    endfunction
    function automatic logic [7:0] pback(logic [7:0] p);
        return (p == FIRST) ? LIMIT - 8'd1 : p - 8'd1;
    endfunction
    function automatic logic [15:0] ainc(logic [15:0] a);
        return {(a[7:0] == 8'hFF) ? pstep(a[15:8]) : a[15:8], a[7:0] + 8'd1};
    endfunction
    function automatic logic [7:0] fstat(bit crc, bit aln, bit grp);
        return {2'b00, grp, 2'b00, aln, crc | aln, !(crc | aln)};
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                n_wr++;
                if (mem_addr[15:8] < FIRST || mem_addr[15:8] >= LIMIT) n_oob++;
                bmem[mem_addr[11:0]] = mem_wdata;
            end
            if (frame_stored)   n_ok++;
            if (frame_dropped)  n_drop++;
            if (frame_missed)   n_miss++;
            if (ring_overwrite) n_ovw++;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic set_cur(logic [7:0] v);
        cur_wr = 1; cur_wdata = v; tick(); cur_wr = 0;
        tick();
        exp_cur = v;
        chk(cur_page == v, "R13", cur_page, v);
    endtask

    task automatic frame(int len, bit crc, bit aln, bit grp, bit mon, bit kr, bit kb, logic [7:0] bnd);
        logic [15:0] a;
        int stop_at;
        bit ovf, keep, okx, endovf;
        logic [7:0] nxt, st;
        int ewr;
        cfg_bnd = bnd; cfg_keep_runt = kr; cfg_keep_bad = kb; cfg_monitor = mon;
        a = {exp_cur, 8'd4}; ovf = 0; stop_at = len;
        for (int i = 0; i < len; i++) begin
            dat[i] = 8'($urandom);
            if (!ovf && a[7:0] == 8'd0 && a[15:8] == bnd) begin ovf = 1; stop_at = i; end
            if (!ovf) begin ea[i] = a; a = ainc(a); end
        end
        keep = (len >= 64 || kr) && (!(crc | aln) || kb);
        nxt = (a[7:0] == 8'd0) ? a[15:8] : pstep(a[15:8]);
        endovf = !mon && !ovf && keep && (nxt == bnd);
        okx = !mon && !ovf && keep && !endovf;
        ewr = mon ? 0 : stop_at + (okx ? 4 : 0);
        n_wr = 0; n_ok = 0; n_drop = 0; n_miss = 0; n_ovw = 0; n_oob = 0;
        rx_sof = 1; tick(); rx_sof = 0;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1; rx_data = dat[i]; tick();
        end
        rx_valid = 0;
        rx_eof = 1; rx_crc_err = crc; rx_align_err = aln; rx_group = grp; tick();
        rx_eof = 0; rx_crc_err = 0; rx_align_err = 0; rx_group = 0;
        repeat (7) tick();
        chk(n_wr == ewr, "R2 write count", n_wr, ewr);
        chk(n_oob == 0, "R12 out-of-ring writes", n_oob, 0);
        if (mon) begin
            chk(n_miss == 1 && n_ok == 0, "R11 missed pulse", n_miss, 1);
            chk(last_status == 8'h50, "R11 status", last_status, 8'h50);
            chk(cur_page == exp_cur, "R11 cur unchanged", cur_page, exp_cur);
        end else if (ovf) begin
            chk(n_ovw == 1 && n_miss == 1 && n_ok == 0, "R9 overwrite+miss", n_ovw, 1);
            chk(last_status == 8'h10, "R9 status", last_status, 8'h10);
            chk(cur_page == exp_cur, "R9 cur unchanged", cur_page, exp_cur);
        end else if (!keep) begin
            chk(n_drop == 1 && n_ok == 0 && n_miss == 0, "R7 R8 drop pulse", n_drop, 1);
            chk(last_status == fstat(crc, aln, grp), "R6 drop status", last_status, fstat(crc, aln, grp));
            chk(cur_page == exp_cur, "R7 cur unchanged", cur_page, exp_cur);
        end else if (endovf) begin
            st = fstat(crc, aln, grp) | 8'h10;
            chk(n_ovw == 1 && n_miss == 1 && n_ok == 0, "R10 end overwrite", n_ovw, 1);
            chk(last_status == st, "R10 status", last_status, st);
            chk(cur_page == exp_cur, "R10 cur unchanged", cur_page, exp_cur);
        end else begin
            st = fstat(crc, aln, grp);
            chk(n_ok == 1 && n_drop == 0 && n_miss == 0, "R5 stored pulse", n_ok, 1);
            chk(cur_page == nxt, "R5 next page", cur_page, nxt);
            chk(last_status == st, "R6 status", last_status, st);
            chk(bmem[{exp_cur[3:0], 8'd0}] == st, "R4 hdr status", bmem[{exp_cur[3:0], 8'd0}], st);
            chk(bmem[{exp_cur[3:0], 8'd1}] == nxt, "R4 hdr next", bmem[{exp_cur[3:0], 8'd1}], nxt);
            chk(bmem[{exp_cur[3:0], 8'd2}] == 8'(len + 4), "R4 hdr count lo", bmem[{exp_cur[3:0], 8'd2}], 8'(len + 4));
            chk(bmem[{exp_cur[3:0], 8'd3}] == 8'((len + 4) >> 8), "R4 hdr count hi", bmem[{exp_cur[3:0], 8'd3}], 8'((len + 4) >> 8));
            begin
                int bad = 0;
                for (int i = 0; i < len; i++) if (bmem[ea[i][11:0]] !== dat[i]) bad++;
                chk(bad == 0, "R2 R3 data bytes", bad, 0);
            end
            exp_cur = nxt;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) tick();
        // R1 reset state
        chk(cur_page == 8'd0 && last_status == 8'd0, "R1 regs", cur_page, 0);
        chk(!mem_we && !frame_stored && !frame_dropped && !frame_missed && !ring_overwrite,
            "R1 outputs", mem_we, 0);
        rst_n = 1; tick();
        set_cur(FIRST);
        frame(100, 0, 0, 0, 0, 0, 0, pback(exp_cur));       // R2 R4 R5
        frame(63, 0, 0, 0, 0, 0, 0, pback(exp_cur));        // R7 runt dropped
        frame(10, 0, 0, 1, 0, 1, 0, pback(exp_cur));        // R7 runt kept, R6 group
        frame(64, 0, 0, 0, 0, 0, 0, pback(exp_cur));        // R7 boundary length
        frame(80, 1, 0, 0, 0, 0, 0, pback(exp_cur));        // R8 crc dropped
        frame(80, 0, 1, 0, 0, 0, 1, pback(exp_cur));        // R8 align kept
        set_cur(LIMIT - 8'd1);
        frame(300, 0, 0, 0, 0, 0, 0, pback(exp_cur));       // R3 wrap
        frame(252, 0, 0, 0, 0, 0, 0, pback(exp_cur));       // page-exact end
        frame(400, 0, 0, 0, 0, 0, 0, pstep(exp_cur));       // R9 mid-frame
        frame(252, 0, 0, 0, 0, 0, 0, pstep(exp_cur));       // R10 end
        frame(120, 0, 0, 0, 1, 0, 0, pback(exp_cur));       // R11 monitor
        for (int k = 0; k < 40; k++) begin
            logic [7:0] b;
            b = ($urandom % 4 == 0) ? FIRST + 8'($urandom % 6) : pback(exp_cur);
            frame($urandom % 600, ($urandom % 6) == 0, ($urandom % 8) == 0, $urandom % 2,
                  ($urandom % 12) == 0, $urandom % 2, $urandom % 2, b);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule